// File: doc/BRIEF.md
# Link-Side Backup Attachment Splitter

This block sits on a mesh link beside a tile and gives the tile's core a second, backup way into the network without adding a port to any router. Every packet arriving on the link is examined at its first flit. When the destination coordinates in that header equal the attached core's own coordinates, the whole packet is handed to the core's backup network-interface port. Any other destination sends the packet onward on the link toward the next router. The core keeps its normal path through the main local port of its own router. When that router has failed, the core is still reachable, and can still send, through this block.

Three flows run at once: link-in to the core's backup port, link-in onward to link-out, and the core's backup port injecting onto link-out. The two flows that share link-out are granted packet by packet. A packet already in progress always keeps link-out until its last flit. The router downstream of link-out reports a fault flag, and the block checks that flag before it starts a new packet on link-out. All paths are combinational with valid/ready handshakes, so the block adds no cycles of latency and holds no flits of its own.

Top module: `link_tap_unit`

## Requirements
- R1: A flit is a 2-bit kind in bits [17:16] (00 body, 01 header, 10 tail, 11 single-flit packet) above a 16-bit payload. A header or single flit carries its destination in payload bits [4:0] as {z[4], y[3:2], x[1:0]}. When that destination equals the parameters (MY_X, MY_Y, MY_Z), the flit appears unchanged on the core port in the same cycle and link-out stays invalid for it.
- R2: A header or single flit with any other destination appears unchanged on link-out in the same cycle, and the core port stays invalid for it.
- R3: The comparison covers all three coordinate fields. A destination that differs from the own address in only x, only y or only z is forwarded to link-out.
- R4: The output chosen for a header is held for all following flits until the tail is accepted, whatever those flits' payload bits hold. A single-flit packet creates no hold.
- R5: A flit moves only in a cycle where valid and ready are both high. A stalled flit stays present and unchanged on its output, with the upstream ready low, and it is delivered exactly once.
- R6: A core-bound packet from link-in and an injected packet from the core move in the same cycle without stalling each other.
- R7: While a packet from either source holds link-out, the other source gets no link-out access and its ready stays low. When both sources offer a header to an idle link-out in the same cycle, the link-in packet goes first.
- R8: While the fault flag is high, no new packet starts on link-out. Link-out stays invalid and the offering source sees ready low. A packet already in progress keeps moving.
- R9: A body or tail flit that arrives on either input while that input has no packet in progress is accepted (ready high) and discarded, and no output becomes valid.
- R10: After synchronous reset, both outputs are invalid and no packet is held, so a body flit from before the reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lin_valid | input | 1 | Link-in flit valid |
| lin_flit | input | 18 | Link-in flit |
| lin_ready | output | 1 | Link-in flit accepted |
| core_valid | output | 1 | Flit valid toward the core's backup port |
| core_flit | output | 18 | Flit toward the core's backup port |
| core_ready | input | 1 | Core backup port accepts the flit |
| inj_valid | input | 1 | Injected flit valid from the core's backup port |
| inj_flit | input | 18 | Injected flit |
| inj_ready | output | 1 | Injected flit accepted |
| lout_valid | output | 1 | Link-out flit valid toward the next router |
| lout_flit | output | 18 | Link-out flit |
| lout_ready | input | 1 | Next router accepts the flit |
| nxt_fault | input | 1 | Fault-status flag of the next router |

## Verification
The directed patterns are: local and remote single flits, and headers whose address is one field away from the own address in each of x, y and z. Together they show whether the decode compares every coordinate or only part of one. Multi-flit packets whose body payloads mimic a foreign address separate a real path lock from a per-flit decode. Stalls on the core port show whether a flit is held or duplicated. Overlapping link-in and injected packets exercise the three outcomes on link-out: the same-cycle tie, ownership in either direction, and the concurrent core-bound case. Fault toggling before and inside a packet, stray non-header flits on an idle input, and a reset in the middle of a packet cover the gating, discard and recovery rules.

// File: rtl/ltap_pkg.sv
package ltap_pkg;
    localparam int CX_W  = 2;
    localparam int CY_W  = 2;
    localparam int CZ_W  = 1;
    localparam int CRD_W = CX_W + CY_W + CZ_W;
    localparam int PAY_W = 16;
    localparam int FLIT_W = PAY_W + 2;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } fkind_e;

    typedef struct packed {
        logic [CZ_W-1:0] z;
        logic [CY_W-1:0] y;
        logic [CX_W-1:0] x;
    } coord_t;

    typedef struct packed {
        fkind_e           kind;
        logic [PAY_W-1:0] pay;
    } flit_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_CORE = 2'd1,
        RT_FWD  = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        OW_NONE = 2'd0,
        OW_PASS = 2'd1,
        OW_INJ  = 2'd2
    } owner_e;

    function automatic logic opens_pkt(input fkind_e k);
        return (k == FK_HEAD) || (k == FK_SOLO);
    endfunction

    function automatic logic closes_pkt(input fkind_e k);
        return (k == FK_TAIL) || (k == FK_SOLO);
    endfunction

    function automatic coord_t dest_of(input flit_t f);
        return coord_t'(f.pay[CRD_W-1:0]);
    endfunction
endpackage

// File: rtl/ltap_addr_match.sv
module ltap_addr_match
    import ltap_pkg::*;
#(
    parameter int MY_X = 1,
    parameter int MY_Y = 2,
    parameter int MY_Z = 1
) (
    input  coord_t dest,
    input  fkind_e kind,
    output logic   is_open,
    output logic   is_local
);
    coord_t me;

    always_comb begin
        me.x = CX_W'(MY_X);
        me.y = CY_W'(MY_Y);
        me.z = CZ_W'(MY_Z);
        is_open  = opens_pkt(kind);
        is_local = (dest.x == me.x) && (dest.y == me.y) && (dest.z == me.z);
    end
endmodule

// File: rtl/ltap_split.sv
module ltap_split
    import ltap_pkg::*;
#(
    parameter int MY_X = 1,
    parameter int MY_Y = 2,
    parameter int MY_Z = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  flit_t in_flit,
    output logic  in_ready,
    output logic  core_valid,
    output flit_t core_flit,
    input  logic  core_ready,
    output logic  fwd_valid,
    output flit_t fwd_flit,
    input  logic  fwd_ready
);
    route_e route_q;
    route_e sel;
    logic   hdr_open;
    logic   hdr_local;
    logic   take;

    ltap_addr_match #(.MY_X(MY_X), .MY_Y(MY_Y), .MY_Z(MY_Z)) match_i (
        .dest    (dest_of(in_flit)),
        .kind    (in_flit.kind),
        .is_open (hdr_open),
        .is_local(hdr_local)
    );

    always_comb begin
        if (route_q != RT_NONE) begin
            sel = route_q;
        end else if (hdr_open) begin
            sel = hdr_local ? RT_CORE : RT_FWD;
        end else begin
            sel = RT_NONE;
        end
        core_valid = in_valid && (sel == RT_CORE);
        fwd_valid  = in_valid && (sel == RT_FWD);
        core_flit  = in_flit;
        fwd_flit   = in_flit;
        case (sel)
            RT_CORE: in_ready = core_ready;
            RT_FWD:  in_ready = fwd_ready;
            default: in_ready = 1'b1;
        endcase
        take = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= RT_NONE;
        end else if (take) begin
            if (route_q == RT_NONE && in_flit.kind == FK_HEAD) begin
                route_q <= sel;
            end else if (route_q != RT_NONE && closes_pkt(in_flit.kind)) begin
                route_q <= RT_NONE;
            end
        end
    end

    logic core_inpkt;
    always_ff @(posedge clk) begin
        if (rst) begin
            core_inpkt <= 1'b0;
        end else if (core_valid && core_ready) begin
            if (core_flit.kind == FK_HEAD) core_inpkt <= 1'b1;
            else if (closes_pkt(core_flit.kind)) core_inpkt <= 1'b0;
        end
    end

    // R1
    core_hdr_is_mine_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && !core_inpkt && opens_pkt(core_flit.kind) |->
            (int'(dest_of(core_flit).x) == MY_X) && (int'(dest_of(core_flit).y) == MY_Y)
            && (int'(dest_of(core_flit).z) == MY_Z));

    // R4
    core_no_interleave_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && core_inpkt |-> !opens_pkt(core_flit.kind));

    // R5
    core_hold_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && !core_ready |=> core_valid && $stable(core_flit));
endmodule

// File: rtl/ltap_merge.sv
module ltap_merge
    import ltap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fault,
    input  logic  a_valid,
    input  flit_t a_flit,
    output logic  a_ready,
    input  logic  b_valid,
    input  flit_t b_flit,
    output logic  b_ready,
    output logic  out_valid,
    output flit_t out_flit,
    input  logic  out_ready
);
    owner_e owner_q;
    owner_e grant;
    logic   a_drop;
    logic   b_drop;

    always_comb begin
        a_drop = (owner_q == OW_NONE) && a_valid && !opens_pkt(a_flit.kind);
        b_drop = (owner_q == OW_NONE) && b_valid && !opens_pkt(b_flit.kind);
        if (owner_q != OW_NONE) begin
            grant = owner_q;
        end else if (!fault && a_valid && opens_pkt(a_flit.kind)) begin
            grant = OW_PASS;
        end else if (!fault && b_valid && opens_pkt(b_flit.kind)) begin
            grant = OW_INJ;
        end else begin
            grant = OW_NONE;
        end
        case (grant)
            OW_PASS: out_valid = a_valid;
            OW_INJ:  out_valid = b_valid;
            default: out_valid = 1'b0;
        endcase
        out_flit = (grant == OW_INJ) ? b_flit : a_flit;
        a_ready  = ((grant == OW_PASS) && out_ready) || a_drop;
        b_ready  = ((grant == OW_INJ) && out_ready) || b_drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OW_NONE;
        end else if (out_valid && out_ready) begin
            if (owner_q == OW_NONE && out_flit.kind == FK_HEAD) begin
                owner_q <= grant;
            end else if (owner_q != OW_NONE && closes_pkt(out_flit.kind)) begin
                owner_q <= OW_NONE;
            end
        end
    end

    logic out_inpkt;
    always_ff @(posedge clk) begin
        if (rst) begin
            out_inpkt <= 1'b0;
        end else if (out_valid && out_ready) begin
            if (out_flit.kind == FK_HEAD) out_inpkt <= 1'b1;
            else if (closes_pkt(out_flit.kind)) out_inpkt <= 1'b0;
        end
    end

    // R7
    lout_no_interleave_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_inpkt |-> !opens_pkt(out_flit.kind));

    // R8
    lout_start_unfaulted_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_inpkt && opens_pkt(out_flit.kind) |-> !fault);

    // R5
    lout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && out_inpkt |=> out_valid && $stable(out_flit));

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_ready && b_ready && !a_drop && !b_drop));
endmodule

// File: rtl/link_tap_unit.sv
module link_tap_unit
    import ltap_pkg::*;
#(
    parameter int MY_X = 1,
    parameter int MY_Y = 2,
    parameter int MY_Z = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lin_valid,
    input  logic [FLIT_W-1:0] lin_flit,
    output logic              lin_ready,
    output logic              core_valid,
    output logic [FLIT_W-1:0] core_flit,
    input  logic              core_ready,
    input  logic              inj_valid,
    input  logic [FLIT_W-1:0] inj_flit,
    output logic              inj_ready,
    output logic              lout_valid,
    output logic [FLIT_W-1:0] lout_flit,
    input  logic              lout_ready,
    input  logic              nxt_fault
);
    flit_t lin_f;
    flit_t inj_f;
    flit_t core_f;
    flit_t fwd_f;
    flit_t lout_f;
    logic  fwd_valid;
    logic  fwd_ready;

    assign lin_f     = flit_t'(lin_flit);
    assign inj_f     = flit_t'(inj_flit);
    assign core_flit = FLIT_W'(core_f);
    assign lout_flit = FLIT_W'(lout_f);

    ltap_split #(.MY_X(MY_X), .MY_Y(MY_Y), .MY_Z(MY_Z)) split_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lin_valid),
        .in_flit   (lin_f),
        .in_ready  (lin_ready),
        .core_valid(core_valid),
        .core_flit (core_f),
        .core_ready(core_ready),
        .fwd_valid (fwd_valid),
        .fwd_flit  (fwd_f),
        .fwd_ready (fwd_ready)
    );

    ltap_merge merge_i (
        .clk      (clk),
        .rst      (rst),
        .fault    (nxt_fault),
        .a_valid  (fwd_valid),
        .a_flit   (fwd_f),
        .a_ready  (fwd_ready),
        .b_valid  (inj_valid),
        .b_flit   (inj_f),
        .b_ready  (inj_ready),
        .out_valid(lout_valid),
        .out_flit (lout_f),
        .out_ready(lout_ready)
    );
endmodule

// File: tb/link_tap_unit_tb_top.sv
module link_tap_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MX = 1;
    localparam int MYY = 2;
    localparam int MZ = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lin_valid = 1'b0;
    logic [17:0] lin_flit = '0;
    logic        lin_ready;
    logic        core_valid;
    logic [17:0] core_flit;
    logic        core_ready = 1'b1;
    logic        inj_valid = 1'b0;
    logic [17:0] inj_flit = '0;
    logic        inj_ready;
    logic        lout_valid;
    logic [17:0] lout_flit;
    logic        lout_ready = 1'b1;
    logic        nxt_fault = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_tap_unit #(.MY_X(MX), .MY_Y(MYY), .MY_Z(MZ)) dut_i (
        .clk(clk), .rst(rst),
        .lin_valid(lin_valid), .lin_flit(lin_flit), .lin_ready(lin_ready),
        .core_valid(core_valid), .core_flit(core_flit), .core_ready(core_ready),
        .inj_valid(inj_valid), .inj_flit(inj_flit), .inj_ready(inj_ready),
        .lout_valid(lout_valid), .lout_flit(lout_flit), .lout_ready(lout_ready),
        .nxt_fault(nxt_fault)
    );

    localparam logic [1:0] K_BODY = 2'b00;
    localparam logic [1:0] K_HEAD = 2'b01;
    localparam logic [1:0] K_TAIL = 2'b10;
    localparam logic [1:0] K_SOLO = 2'b11;

    function automatic logic [17:0] mk(input logic [1:0] k, input int x, input int y,
                                       input int z, input int tag);
        return {k, 11'(tag), 1'(z), 2'(y), 2'(x)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_inputs();
        lin_valid = 1'b0;
        inj_valid = 1'b0;
        core_ready = 1'b1;
        lout_ready = 1'b1;
        nxt_fault = 1'b0;
    endtask

    task automatic t_reset();
        idle_inputs();
        settle();
        check("R10", "core_valid after reset", 32'(core_valid), 0);
        check("R10", "lout_valid after reset", 32'(lout_valid), 0);
    endtask

    task automatic t_local_solo();
        logic [17:0] f = mk(K_SOLO, MX, MYY, MZ, 5);
        lin_valid = 1'b1; lin_flit = f; settle();
        check("R1", "core_valid", 32'(core_valid), 1);
        check("R1", "core_flit", 32'(core_flit), 32'(f));
        check("R1", "lout_valid", 32'(lout_valid), 0);
        tick(); lin_valid = 1'b0;
    endtask

    task automatic t_remote_pkt();
        logic [17:0] h = mk(K_HEAD, 0, 0, 0, 7);
        logic [17:0] b = mk(K_BODY, MX, MYY, MZ, 8);
        logic [17:0] t = mk(K_TAIL, 3, 3, 1, 9);
        lin_valid = 1'b1; lin_flit = h; settle();
        check("R2", "lout head", 32'(lout_flit), 32'(h));
        check("R2", "core_valid", 32'(core_valid), 0);
        tick(); lin_flit = b; settle();
        check("R4", "lout body", 32'(lout_valid && lout_flit == b), 1);
        check("R4", "core_valid on body", 32'(core_valid), 0);
        tick(); lin_flit = t; settle();
        check("R4", "lout tail", 32'(lout_valid && lout_flit == t), 1);
        tick(); lin_valid = 1'b0;
    endtask

    task automatic t_addr_fields();
        logic [17:0] f;
        for (int i = 0; i < 3; i++) begin
            f = mk(K_SOLO, (i == 0) ? MX ^ 1 : MX, (i == 1) ? MYY ^ 1 : MYY,
                   (i == 2) ? MZ ^ 1 : MZ, i);
            lin_valid = 1'b1; lin_flit = f; settle();
            check("R3", "one field differs -> lout", 32'(lout_valid && lout_flit == f), 1);
            check("R3", "one field differs -> no core", 32'(core_valid), 0);
            tick();
        end
        lin_valid = 1'b0;
    endtask

    task automatic t_lock();
        logic [17:0] b = mk(K_BODY, 0, 0, 0, 3);
        lin_valid = 1'b1; lin_flit = mk(K_HEAD, MX, MYY, MZ, 1); tick();
        lin_flit = b; settle();
        check("R4", "body with foreign bits stays on core", 32'(core_valid && core_flit == b), 1);
        check("R4", "body not on lout", 32'(lout_valid), 0);
        tick(); lin_flit = mk(K_TAIL, 0, 0, 0, 4); settle();
        check("R4", "tail on core", 32'(core_valid), 1);
        tick(); lin_flit = mk(K_SOLO, 0, 1, 0, 2); settle();
        check("R4", "released after tail", 32'(lout_valid), 1);
        tick(); lin_valid = 1'b0;
    endtask

    task automatic t_backpressure();
        logic [17:0] h = mk(K_HEAD, MX, MYY, MZ, 11);
        logic [17:0] t = mk(K_TAIL, 0, 0, 0, 12);
        core_ready = 1'b0; lin_valid = 1'b1; lin_flit = h; settle();
        check("R5", "stalled: lin_ready", 32'(lin_ready), 0);
        tick(); settle();
        check("R5", "stalled flit held", 32'(core_valid && core_flit == h), 1);
        core_ready = 1'b1; settle();
        check("R5", "released: lin_ready", 32'(lin_ready), 1);
        tick(); lin_flit = t; settle();
        check("R5", "no duplicate, tail next", 32'(core_valid && core_flit == t), 1);
        tick(); lin_valid = 1'b0;
    endtask

    task automatic t_concurrent();
        logic [17:0] ih = mk(K_HEAD, 2, 2, 0, 21);
        lin_valid = 1'b1; lin_flit = mk(K_HEAD, MX, MYY, MZ, 20);
        inj_valid = 1'b1; inj_flit = ih; settle();
        check("R6", "core and lout both valid", 32'({core_valid, lout_valid}), 3);
        check("R6", "lout carries injected", 32'(lout_flit), 32'(ih));
        check("R6", "both readies", 32'({lin_ready, inj_ready}), 3);
        tick();
        lin_flit = mk(K_TAIL, 0, 0, 0, 22); inj_flit = mk(K_TAIL, 0, 0, 0, 23); settle();
        check("R6", "tails both move", 32'({lin_ready, inj_ready}), 3);
        tick(); lin_valid = 1'b0; inj_valid = 1'b0;
    endtask

    task automatic t_contention();
        logic [17:0] pb = mk(K_BODY, 0, 0, 0, 31);
        logic [17:0] is = mk(K_SOLO, 3, 0, 0, 32);
        logic [17:0] ls = mk(K_SOLO, 0, 3, 0, 33);
        lin_valid = 1'b1; lin_flit = mk(K_HEAD, 0, 0, 0, 30); tick();
        lin_flit = pb; inj_valid = 1'b1; inj_flit = is; settle();
        check("R7", "pass packet keeps lout", 32'(lout_flit), 32'(pb));
        check("R7", "inj stalled", 32'(inj_ready), 0);
        tick(); lin_flit = mk(K_TAIL, 0, 0, 0, 34); settle();
        check("R7", "inj stalled on tail", 32'(inj_ready), 0);
        tick(); lin_valid = 1'b0; settle();
        check("R7", "inj after release", 32'(lout_valid && lout_flit == is && inj_ready), 1);
        tick();
        lin_valid = 1'b1; lin_flit = ls; settle();
        check("R7", "tie: link-in wins", 32'(lout_flit), 32'(ls));
        check("R7", "tie: inj waits", 32'(inj_ready), 0);
        tick(); lin_valid = 1'b0; tick(); inj_valid = 1'b0;
        inj_valid = 1'b1; inj_flit = mk(K_HEAD, 3, 3, 0, 35); tick();
        inj_flit = mk(K_BODY, 0, 0, 0, 36);
        lin_valid = 1'b1; lin_flit = ls; settle();
        check("R7", "inj packet holds lout", 32'({lin_ready, lout_flit == inj_flit}), 1);
        tick(); inj_flit = mk(K_TAIL, 0, 0, 0, 37); tick(); inj_valid = 1'b0; settle();
        check("R7", "link-in after inj tail", 32'(lout_valid && lout_flit == ls), 1);
        tick(); lin_valid = 1'b0;
    endtask

    task automatic t_fault();
        logic [17:0] f = mk(K_SOLO, 0, 0, 1, 40);
        nxt_fault = 1'b1; lin_valid = 1'b1; lin_flit = f;
        inj_valid = 1'b1; inj_flit = mk(K_SOLO, 2, 0, 0, 41); settle();
        check("R8", "no start under fault", 32'(lout_valid), 0);
        check("R8", "sources stalled", 32'({lin_ready, inj_ready}), 0);
        tick(); inj_valid = 1'b0; nxt_fault = 1'b0; settle();
        check("R8", "starts after fault clears", 32'(lout_valid && lout_flit == f), 1);
        tick();
        lin_flit = mk(K_HEAD, 0, 0, 0, 42); tick();
        nxt_fault = 1'b1; lin_flit = mk(K_BODY, 0, 0, 0, 43); settle();
        check("R8", "in-progress continues", 32'(lout_valid && lin_ready), 1);
        tick(); lin_flit = mk(K_TAIL, 0, 0, 0, 44); tick();
        lin_valid = 1'b0; nxt_fault = 1'b0;
    endtask

    task automatic t_stray();
        lin_valid = 1'b1; lin_flit = mk(K_BODY, MX, MYY, MZ, 50); settle();
        check("R9", "link-in stray consumed", 32'(lin_ready), 1);
        check("R9", "link-in stray no output", 32'({core_valid, lout_valid}), 0);
        tick(); lin_valid = 1'b0;
        inj_valid = 1'b1; inj_flit = mk(K_TAIL, 0, 0, 0, 51); settle();
        check("R9", "inj stray consumed", 32'(inj_ready), 1);
        check("R9", "inj stray no output", 32'(lout_valid), 0);
        tick(); inj_valid = 1'b0;
    endtask

    task automatic t_reset_mid();
        lin_valid = 1'b1; lin_flit = mk(K_HEAD, 0, 0, 0, 60); tick();
        lin_valid = 1'b0; rst = 1'b1; tick(); rst = 1'b0;
        lin_valid = 1'b1; lin_flit = mk(K_BODY, 0, 0, 0, 61); settle();
        check("R10", "body after reset discarded", 32'({lin_ready, core_valid, lout_valid}), 4);
        tick(); lin_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_local_solo();
        t_remote_pkt();
        t_addr_fields();
        t_lock();
        t_backpressure();
        t_concurrent();
        t_contention();
        t_fault();
        t_stray();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule